// File: doc/BRIEF.md
# Luma AC Coefficient Rescaler (4x4)

This block rescales the sixteen signed coefficients of one 4x4 luma AC residual block in a video decoder. Coefficients enter one per beat in raster order over a valid/ready stream. A quantization parameter comes with the first beat of each block. Each coefficient is multiplied by a level-scale factor. The row of the factor table is chosen by the parameter modulo 6, and the column by the coefficient's position class. The factor is shifted left by the parameter divided by 6 before the multiply, and only the low 16 bits of each product are kept. The rescaled coefficients leave on a second valid/ready stream in the order they arrived. A one-cycle pulse marks the handoff of the sixteenth result of each block.

Back-pressure rules: the input is taken in a cycle only when `in_valid` and `in_ready` are both high. `in_ready` is high whenever the output register is empty or is being emptied in that cycle. While `out_valid` is high and `out_ready` is low, the output beat holds. A producer must hold `in_coef` and `in_qp` steady while `in_valid` is high and `in_ready` is low.

Top module: `lac_rescale4x4`

## Requirements
- R1: After reset `out_valid` and `blk_done` are low, `in_ready` is high, and the next accepted beat is position 0 of a block.
- R2: `in_qp` is sampled only on the beat at position 0. Its value on positions 1 to 15 has no effect on any result of that block.
- R3: The factor row is the effective parameter modulo 6. The factor is shifted left by the effective parameter divided by 6, which is a shift of 0 to 8.
- R4: The position is p = 4*row + col in raster order. Class A (both row and col even: p = 0, 2, 8, 10) uses factors {10,11,13,14,16,18}. Class B (both odd: p = 5, 7, 13, 15) uses {16,18,20,23,25,29}. Class C (all other positions) uses {13,14,16,18,20,23}. Each list is indexed by the row 0..5.
- R5: Each result is the low 16 bits of the signed coefficient times the shifted factor, read as a signed 16-bit value. A zero coefficient gives zero.
- R6: Each accepted beat yields exactly one result. Results keep the input order, and a result is valid in the cycle after its beat is accepted.
- R7: `in_ready` equals NOT `out_valid` OR `out_ready`. A stalled result keeps `out_valid` high and `out_coef` unchanged until it is taken.
- R8: `blk_done` is high for exactly the cycle in which the result for position 15 is taken (`out_valid` and `out_ready` both high), and is low at all other times.
- R9: A parameter value above 51 is treated as 51 (row 3, shift 8).
- R10: After 16 accepted beats, position counting wraps, and the next beat starts a new block with a new parameter.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Input beat present |
| in_ready | output | 1 | Block can take an input beat |
| in_coef | input | 16 | Signed input coefficient |
| in_qp | input | 6 | Quantization parameter, sampled at position 0 |
| out_valid | output | 1 | Result beat present |
| out_ready | input | 1 | Consumer takes the result |
| out_coef | output | 16 | Signed rescaled coefficient |
| blk_done | output | 1 | Pulse when the 16th result of a block is taken |

## Verification
A wrong position counter shows up at once: the next result uses the wrong class factor, and `blk_done` appears on the wrong beat. A stale or overwritten parameter register changes every later result in the block, starting with the beat after position 0. A wrong ready term either repeats or drops a result. The per-cycle queue comparison flags this on the same beat, and the same comparison catches changes to a stalled beat one cycle after the stall.

// File: rtl/lac_pkg.sv
package lac_pkg;
  typedef enum logic [1:0] {
    CLS_A = 2'd0,
    CLS_B = 2'd1,
    CLS_C = 2'd2
  } pos_cls_e;

  localparam int FACTOR_W = 5;
  localparam int MAX_SHIFT = 8;
  localparam int NUM_CLS = 3;

  function automatic logic [FACTOR_W-1:0] base_factor(input logic [2:0] row,
                                                      input pos_cls_e cls);
    logic [FACTOR_W-1:0] f;
    f = '0;
    unique case (cls)
      CLS_A: case (row)
        3'd0: f = 5'd10; 3'd1: f = 5'd11; 3'd2: f = 5'd13;
        3'd3: f = 5'd14; 3'd4: f = 5'd16; default: f = 5'd18;
      endcase
      CLS_B: case (row)
        3'd0: f = 5'd16; 3'd1: f = 5'd18; 3'd2: f = 5'd20;
        3'd3: f = 5'd23; 3'd4: f = 5'd25; default: f = 5'd29;
      endcase
      default: case (row)
        3'd0: f = 5'd13; 3'd1: f = 5'd14; 3'd2: f = 5'd16;
        3'd3: f = 5'd18; 3'd4: f = 5'd20; default: f = 5'd23;
      endcase
    endcase
    return f;
  endfunction
endpackage

// File: rtl/lac_factor_gen.sv
module lac_factor_gen
  import lac_pkg::*;
#(
  parameter int QP_W = 6,
  parameter int QP_MAX = 51,
  parameter int SCALE_W = FACTOR_W + MAX_SHIFT
) (
  input  logic [QP_W-1:0]            qp,
  output logic [NUM_CLS*SCALE_W-1:0] scl_flat
);
  logic [QP_W-1:0] qp_c;
  logic [2:0]      row;
  logic [3:0]      shamt;

  always_comb begin
    // R9: out-of-range parameter clamps to the top value
    qp_c  = (int'(qp) > QP_MAX) ? QP_W'(QP_MAX) : qp;
    row   = 3'(qp_c % QP_W'(6));
    shamt = 4'(qp_c / QP_W'(6));
  end

  genvar g;
  generate
    for (g = 0; g < NUM_CLS; g++) begin : g_cls
      always_comb begin
        scl_flat[g*SCALE_W +: SCALE_W] =
          SCALE_W'(base_factor(row, pos_cls_e'(g))) << shamt;
      end
    end
  endgenerate

  // R3
  always_comb begin
    shift_range_chk: assert (shamt <= 4'(MAX_SHIFT));
  end
endmodule

// File: rtl/lac_pos_class.sv
module lac_pos_class
  import lac_pkg::*;
#(
  parameter int POS_W = 4
) (
  input  logic [POS_W-1:0] pos,
  output pos_cls_e         cls
);
  localparam int COL_W = POS_W / 2;
  logic row_odd, col_odd;

  always_comb begin
    row_odd = pos[COL_W];
    col_odd = pos[0];
    if (!row_odd && !col_odd)     cls = CLS_A;
    else if (row_odd && col_odd)  cls = CLS_B;
    else                          cls = CLS_C;
  end
endmodule

// File: rtl/lac_mul.sv
module lac_mul #(
  parameter int COEF_W = 16,
  parameter int SCALE_W = 13
) (
  input  logic signed [COEF_W-1:0] coef,
  input  logic [SCALE_W-1:0]       scale,
  output logic signed [COEF_W-1:0] prod
);
  localparam int FULL_W = COEF_W + SCALE_W + 1;
  logic signed [FULL_W-1:0] full;
  logic signed [SCALE_W:0]  s_scale;

  always_comb begin
    s_scale = $signed({1'b0, scale});
    full    = FULL_W'(coef) * FULL_W'(s_scale);
    prod    = full[COEF_W-1:0];
  end
endmodule

// File: rtl/lac_rescale4x4.sv
module lac_rescale4x4
  import lac_pkg::*;
#(
  parameter int COEF_W = 16,
  parameter int QP_W = 6,
  parameter int QP_MAX = 51,
  parameter int POS_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [COEF_W-1:0] in_coef,
  input  logic [QP_W-1:0]   in_qp,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [COEF_W-1:0] out_coef,
  output logic              blk_done
);
  localparam int SCALE_W = FACTOR_W + MAX_SHIFT;
  localparam logic [POS_W-1:0] LAST_POS = '1;

  logic [POS_W-1:0]            pos_q;
  logic [QP_W-1:0]             qp_q, qp_eff;
  logic [NUM_CLS*SCALE_W-1:0]  scl_flat;
  pos_cls_e                    cls;
  logic [SCALE_W-1:0]          scale_sel;
  logic signed [COEF_W-1:0]    prod;
  logic                        in_fire, last_q;

  assign in_ready = !out_valid || out_ready;
  assign in_fire  = in_valid && in_ready;
  assign qp_eff   = (pos_q == '0) ? in_qp : qp_q;

  lac_factor_gen #(.QP_W(QP_W), .QP_MAX(QP_MAX), .SCALE_W(SCALE_W)) u_fac (
    .qp(qp_eff), .scl_flat(scl_flat));

  lac_pos_class #(.POS_W(POS_W)) u_cls (.pos(pos_q), .cls(cls));

  assign scale_sel = scl_flat[int'(cls)*SCALE_W +: SCALE_W];

  lac_mul #(.COEF_W(COEF_W), .SCALE_W(SCALE_W)) u_mul (
    .coef($signed(in_coef)), .scale(scale_sel), .prod(prod));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pos_q     <= '0;
      qp_q      <= '0;
      out_valid <= 1'b0;
      out_coef  <= '0;
      last_q    <= 1'b0;
    end else begin
      if (in_fire) begin
        pos_q     <= pos_q + 1'b1;
        if (pos_q == '0) qp_q <= in_qp;
        out_valid <= 1'b1;
        out_coef  <= prod;
        last_q    <= (pos_q == LAST_POS);
      end else if (out_ready) begin
        out_valid <= 1'b0;
      end
    end
  end

  assign blk_done = out_valid && out_ready && last_q;

  // R7
  hold_stall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_coef)));

  // R8
  done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    blk_done |=> !blk_done);

  // R2
  qp_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_fire && pos_q != '0) |=> $stable(qp_q));

  // R5
  zero_coef_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_fire && in_coef == '0) |=> (out_coef == '0));

  // R10
  pos_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_fire && pos_q == LAST_POS) |=> (pos_q == '0));
endmodule

// File: tb/lac_rescale4x4_test.sv
module lac_rescale4x4_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [15:0] in_coef = '0;
  logic [5:0]  in_qp = '0;
  logic        out_valid;
  logic        out_ready = 1'b0;
  logic [15:0] out_coef;
  logic        blk_done;

  always #5 clk = ~clk;

  lac_rescale4x4 uut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_coef(in_coef), .in_qp(in_qp), .out_valid(out_valid),
    .out_ready(out_ready), .out_coef(out_coef), .blk_done(blk_done));

  int checks = 0;
  int errors = 0;
  int cycles = 0;
  logic [15:0] expq[$];
  logic        expdone[$];

  localparam int PASSES = 3;
  localparam int NBLK = 56 * PASSES;
  localparam int TOTAL = NBLK * 16;

  function automatic int ref_factor(int qp, int p);
    int q, r, c, k;
    int ta[6] = '{10, 11, 13, 14, 16, 18};
    int tb[6] = '{16, 18, 20, 23, 25, 29};
    int tc[6] = '{13, 14, 16, 18, 20, 23};
    q = (qp > 51) ? 51 : qp;
    r = p / 4; c = p % 4;
    if ((r % 2 == 0) && (c % 2 == 0)) k = ta[q % 6];
    else if ((r % 2 == 1) && (c % 2 == 1)) k = tb[q % 6];
    else k = tc[q % 6];
    return k * (1 << (q / 6));
  endfunction

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  initial begin
    while (cycles < 100000) begin
      @(posedge clk);
      cycles++;
    end
    check(1'b0, "watchdog R6", cycles, 0);
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    int sent = 0;
    int cur_qp = 0;
    bit pending = 0;
    bit prev_stall = 0;
    logic [15:0] prev_coef = '0;

    repeat (3) @(negedge clk);
    // R1 reset state
    check(out_valid == 1'b0, "R1 out_valid", int'(out_valid), 0);
    check(in_ready == 1'b1, "R1 in_ready", int'(in_ready), 1);
    check(blk_done == 1'b0, "R1 blk_done", int'(blk_done), 0);
    rst_n = 1'b1;

    while (sent < TOTAL || expq.size() != 0) begin
      @(negedge clk);
      if (!pending) begin
        if (sent < TOTAL && ($urandom % 4) != 0) begin
          int p, blk;
          logic signed [15:0] cf;
          p = sent % 16;
          blk = sent / 16;
          case ($urandom % 8)
            0: cf = 16'sh8000;
            1: cf = 16'sh7fff;
            2: cf = 16'sd0;
            3: cf = 16'($signed(int'($urandom % 64)) - 32);
            default: cf = 16'($urandom);
          endcase
          in_coef = cf;
          // R2: junk qp on positions other than 0
          in_qp = (p == 0) ? 6'(blk % 56) : 6'($urandom);
          if (p == 0) cur_qp = blk % 56;
          in_valid = 1'b1;
          pending = 1;
        end else begin
          in_valid = 1'b0;
        end
      end
      out_ready = ($urandom % 4) != 0;
      #1;
      // R7: stalled beat held
      if (prev_stall) begin
        check(out_valid == 1'b1, "R7 stall valid", int'(out_valid), 1);
        check(out_coef == prev_coef, "R7 stall data", int'(out_coef), int'(prev_coef));
      end
      check(in_ready == (!out_valid || out_ready), "R7 ready", int'(in_ready),
            int'(!out_valid || out_ready));
      if (out_valid && out_ready) begin
        if (expq.size() == 0) begin
          check(1'b0, "R6 extra result", int'(out_coef), 0);
        end else begin
          logic [15:0] e;
          logic ed;
          e = expq.pop_front();
          ed = expdone.pop_front();
          // R3 R4 R5 R9 R10 value and order
          check(out_coef == e, "R3/R4/R5/R6/R9/R10 value", int'($signed(out_coef)),
                int'($signed(e)));
          check(blk_done == ed, "R8 done", int'(blk_done), int'(ed));
        end
      end else begin
        check(blk_done == 1'b0, "R8 idle done", int'(blk_done), 0);
      end
      prev_stall = out_valid && !out_ready;
      prev_coef = out_coef;
      if (in_valid && in_ready) begin
        int p;
        logic signed [31:0] full;
        p = sent % 16;
        full = 32'($signed(in_coef)) * 32'(ref_factor(cur_qp, p));
        expq.push_back(full[15:0]);
        expdone.push_back(p == 15);
        sent++;
        pending = 0;
      end
    end
    @(negedge clk);
    check(out_valid == 1'b0 || !out_ready, "R6 drained", int'(out_valid), 0);
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule